// File: doc/BRIEF.md
# Block-Storage Task-File Register Interface

This block is the target-side register set of a small block-storage device that uses the classic parallel-disk register layout. A host reaches it through one byte-addressed port that has an address, a read strobe, a write strobe, 32-bit write data and combinational read data. Through this port the host programs a sector count, a 24-bit block address, a drive/head byte and a control byte. A byte written to the command offset launches an operation at once. The host then watches the status byte for the busy and data-request flags. Sector data moves through a 32-bit data window, 128 words per 512-byte sector. Completion is signalled on an interrupt line, and the host can mask that line in the control byte.

Two commands are recognised: read one sector (0x20) and write one sector (0x30). A small on-chip store of `SECTORS` sectors takes the place of the media. The sector is picked by the low bits of block-address byte 0. Reads pass through a fixed busy latency before the data can be pulled. Writes take the data first and then stay busy for the same latency while they commit. Unknown opcodes and a request for the absent second drive finish at once with an error code.

Top module: `blkdev_taskfile`

## Requirements
- R1: Offsets 0x1F2..0x1F5 read back the byte last written to them (sector count and block-address bytes 0, 1 and 2). Offset 0x1F6 reads {1, lba-mode, 1, drive, addr[27:24]}, so bits 7 and 5 always read 1. Offset 0x1F1 reads the error byte. Every unmapped offset reads 0.
- R2: The status byte at 0x1F7 is, from bit 7 to bit 0: busy, ready, fault, seek, data-request, corrected, index, error. Ready equals the inverse of busy. Fault, seek, corrected and index read 0. After reset the status byte is 0x40, the error byte is 0 and irq is low.
- R3: A read command (0x20) to drive 0 sets busy for exactly `LATENCY` cycles after the command cycle. It then shows status 0x48 (ready and data-request).
- R4: During a read transfer, each read of the data port (0x1F0) returns the next of 128 words, taken from sector addr[7:0] mod `SECTORS` as last written. After the 128th word, data-request clears.
- R5: A write command (0x30) shows status 0x48 in the very next cycle. It accepts 128 data-port writes, then holds busy for exactly `LATENCY` cycles and then returns to status 0x40.
- R6: When a command completes, irq rises if control bit 1 is 0. It stays low if control bit 1 is 1. It does not rise when the read data becomes available.
- R7: A read of the status byte at 0x1F7 clears irq. A read of the alternate status at 0x3F6 returns the same byte and leaves irq unchanged.
- R8: An opcode other than 0x20 or 0x30 sets error byte 0x04 (aborted, bit 2) and status 0x41, never sets busy, and completes with the interrupt.
- R9: A command issued with drive bit 4 of 0x1F6 set fails with error byte 0x10 (no ID, bit 4) and status 0x41, and completes with the interrupt.
- R10: Writing control (0x3F6) with bit 2 set ends any command at once. Status becomes 0x40, the error byte becomes 0 and irq goes low. Commands and register writes are ignored until bit 2 is written back to 0.
- R11: Writes to the register offsets 0x1F2..0x1F7 are ignored while a command is active. Data-port reads outside a read transfer return 0. Data-port writes outside a write transfer do not change the store.
- R12: An accepted read or write command clears the error byte and the status error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 10 | Byte address of the register access |
| rd_en | input | 1 | Read strobe; side effects take place at the clock edge |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data; registers use bits 7:0, the data port uses all 32 bits |
| rdata | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | Completion interrupt, level, cleared by a status read |

## Verification
Full-sector transfers use patterns that depend on the word index and the sector, so a data-pointer slip, a swapped sector index or a write that lands in the wrong slot each show as a different wrong word. Two sectors are written and read back in turn to tell sector selection apart from plain last-write echo. Error paths run with both a bad opcode and a drive-1 request, because each leaves its own error code. Soft reset is applied in the middle of a write transfer and again after an error, which separates clearing the phase from clearing the error state. Busy lengths are measured by polling the alternate status, so that the interrupt is left untouched while the length is counted.

// File: rtl/blkdev_taskfile.sv
module blkdev_taskfile #(
  parameter int SECTORS = 4,
  parameter int WORDS   = 128,
  parameter int LATENCY = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [9:0]  addr,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  localparam int SEC_W = $clog2(SECTORS);
  localparam int PTR_W = $clog2(WORDS);
  localparam int IDX_W = SEC_W + PTR_W;
  localparam int CNT_W = $clog2(LATENCY + 1);
  localparam int DEPTH = SECTORS * WORDS;
  localparam logic [9:0] A_DATA = 10'h1F0, A_ERR = 10'h1F1, A_CNT = 10'h1F2,
                         A_LBA0 = 10'h1F3, A_LBA1 = 10'h1F4, A_LBA2 = 10'h1F5,
                         A_DH = 10'h1F6, A_CMD = 10'h1F7, A_CTRL = 10'h3F6;
  localparam logic [7:0] OP_RD = 8'h20, OP_WR = 8'h30;
  localparam logic [7:0] E_ABORT = 8'h04, E_NOID = 8'h10;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY - 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(WORDS - 1);

  typedef enum logic [2:0] {S_IDLE, S_RWAIT, S_RXFER, S_WXFER, S_WDONE} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic [PTR_W-1:0] ptr;
  logic [7:0]       sec_cnt, lba0, lba1, lba2, err_reg;
  logic             dh_mode, dh_drv;
  logic [3:0]       dh_hi;
  logic             ctrl_nien, ctrl_srst, err_st, irq_q;
  logic [31:0]      mem [DEPTH];

  logic w_ctrl, w_cmd, w_data, r_data, r_stat, srst_now, mem_we;
  logic st_busy, st_drq;
  logic [7:0] status;
  logic [IDX_W-1:0] idx;

  assign w_ctrl   = wr_en && addr == A_CTRL;
  assign w_cmd    = wr_en && addr == A_CMD;
  assign w_data   = wr_en && addr == A_DATA;
  assign r_data   = rd_en && addr == A_DATA;
  assign r_stat   = rd_en && addr == A_CMD;
  assign srst_now = ctrl_srst || (w_ctrl && wdata[2]);
  assign st_busy  = state == S_RWAIT || state == S_WDONE;
  assign st_drq   = state == S_RXFER || state == S_WXFER;
  assign status   = {st_busy, ~st_busy, 2'b00, st_drq, 2'b00, err_st};
  assign idx      = {lba0[SEC_W-1:0], ptr};
  assign mem_we   = state == S_WXFER && w_data && !srst_now;
  assign irq      = irq_q;

  always_ff @(posedge clk) begin
    if (mem_we) mem[idx] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;  cnt <= '0;  ptr <= '0;
      sec_cnt <= '0; lba0 <= '0; lba1 <= '0; lba2 <= '0;
      dh_mode <= 1'b0; dh_drv <= 1'b0; dh_hi <= '0;
      err_reg <= '0; err_st <= 1'b0; irq_q <= 1'b0;
      ctrl_nien <= 1'b0; ctrl_srst <= 1'b0;
    end else begin
      if (w_ctrl) begin
        ctrl_nien <= wdata[1];
        ctrl_srst <= wdata[2];
      end
      if (r_stat) irq_q <= 1'b0;
      if (srst_now) begin
        state <= S_IDLE; ptr <= '0; cnt <= '0;
        err_st <= 1'b0; err_reg <= '0; irq_q <= 1'b0;
      end else begin
        unique case (state)
          S_IDLE: begin
            if (wr_en) begin
              unique case (addr)
                A_CNT:  sec_cnt <= wdata[7:0];
                A_LBA0: lba0 <= wdata[7:0];
                A_LBA1: lba1 <= wdata[7:0];
                A_LBA2: lba2 <= wdata[7:0];
                A_DH: begin
                  dh_mode <= wdata[6];
                  dh_drv  <= wdata[4];
                  dh_hi   <= wdata[3:0];
                end
                default: ;
              endcase
            end
            if (w_cmd) begin
              if (dh_drv) begin
                err_reg <= E_NOID; err_st <= 1'b1; irq_q <= ~ctrl_nien;
              end else if (wdata[7:0] == OP_RD) begin
                err_reg <= '0; err_st <= 1'b0;
                state <= S_RWAIT; cnt <= CNT_LOAD;
              end else if (wdata[7:0] == OP_WR) begin
                err_reg <= '0; err_st <= 1'b0;
                state <= S_WXFER; ptr <= '0;
              end else begin
                err_reg <= E_ABORT; err_st <= 1'b1; irq_q <= ~ctrl_nien;
              end
            end
          end
          S_RWAIT: begin
            if (cnt == '0) begin
              state <= S_RXFER; ptr <= '0;
            end else cnt <= cnt - 1'b1;
          end
          S_RXFER: begin
            if (r_data) begin
              ptr <= ptr + 1'b1;
              if (ptr == PTR_LAST) begin
                state <= S_IDLE; irq_q <= ~ctrl_nien;
              end
            end
          end
          S_WXFER: begin
            if (w_data) begin
              ptr <= ptr + 1'b1;
              if (ptr == PTR_LAST) begin
                state <= S_WDONE; cnt <= CNT_LOAD;
              end
            end
          end
          S_WDONE: begin
            if (cnt == '0) begin
              state <= S_IDLE; irq_q <= ~ctrl_nien;
            end else cnt <= cnt - 1'b1;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (addr)
      A_DATA:         rdata = (state == S_RXFER) ? mem[idx] : 32'h0;
      A_ERR:          rdata = {24'h0, err_reg};
      A_CNT:          rdata = {24'h0, sec_cnt};
      A_LBA0:         rdata = {24'h0, lba0};
      A_LBA1:         rdata = {24'h0, lba1};
      A_LBA2:         rdata = {24'h0, lba2};
      A_DH:           rdata = {24'h0, 1'b1, dh_mode, 1'b1, dh_drv, dh_hi};
      A_CMD, A_CTRL:  rdata = {24'h0, status};
      default:        rdata = 32'h0;
    endcase
  end

  p_rd_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && w_cmd && wdata[7:0] == OP_RD && !dh_drv && !srst_now) |=> (st_busy && !st_drq));

  p_wr_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && w_cmd && wdata[7:0] == OP_WR && !dh_drv && !srst_now) |=> (st_drq && !st_busy));

  p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> !$past(ctrl_nien));

  p_stat_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (r_stat && !wr_en && state == S_IDLE) |=> !irq_q);

  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && w_cmd && !dh_drv && !srst_now && wdata[7:0] != OP_RD && wdata[7:0] != OP_WR)
      |=> (err_st && err_reg == E_ABORT && !st_busy));

  p_srst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (w_ctrl && wdata[2]) |=> (!st_busy && !st_drq && !err_st && !irq_q));
endmodule

// File: tb/tb_blkdev_taskfile.sv
module tb_blkdev_taskfile;
  localparam int SECTORS = 4, WORDS = 128, LATENCY = 8;
  localparam logic [9:0] A_DATA = 10'h1F0, A_ERR = 10'h1F1, A_CNT = 10'h1F2,
    A_LBA0 = 10'h1F3, A_LBA1 = 10'h1F4, A_LBA2 = 10'h1F5, A_DH = 10'h1F6,
    A_CMD = 10'h1F7, A_ALT = 10'h3F6;

  logic clk = 0, rst_n = 0, rd_en = 0, wr_en = 0, irq;
  logic [9:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  int checks = 0, fails = 0;
  bit running = 0;

  always #4 clk = ~clk;

  blkdev_taskfile #(.SECTORS(SECTORS), .WORDS(WORDS), .LATENCY(LATENCY)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  // behavioural reference: phase 0 idle, 1 read wait, 2 read xfer, 3 write xfer, 4 write commit
  int m_ph, m_cnt, m_ptr;
  bit m_err, m_irq, m_nien, m_srst, m_mode, m_drv, m_sr;
  logic [7:0] m_errb, m_cnt_r, m_l0, m_l1, m_l2;
  logic [3:0] m_hi;
  logic [31:0] m_mem [SECTORS*WORDS];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_ptr = 0; m_err = 0; m_irq = 0; m_nien = 0; m_srst = 0;
      m_mode = 0; m_drv = 0; m_hi = 0; m_errb = 0; m_cnt_r = 0; m_l0 = 0; m_l1 = 0; m_l2 = 0;
    end else begin
      m_sr = m_srst || (wr_en && addr == A_ALT && wdata[2]);
      if (rd_en && addr == A_CMD) m_irq = 0;
      if (m_sr) begin
        m_ph = 0; m_ptr = 0; m_err = 0; m_errb = 0; m_irq = 0;
      end else if (m_ph == 0) begin
        if (wr_en && addr == A_CNT) m_cnt_r = wdata[7:0];
        if (wr_en && addr == A_LBA0) m_l0 = wdata[7:0];
        if (wr_en && addr == A_LBA1) m_l1 = wdata[7:0];
        if (wr_en && addr == A_LBA2) m_l2 = wdata[7:0];
        if (wr_en && addr == A_DH) begin m_mode = wdata[6]; m_drv = wdata[4]; m_hi = wdata[3:0]; end
        if (wr_en && addr == A_CMD) begin
          if (m_drv) begin m_errb = 8'h10; m_err = 1; if (!m_nien) m_irq = 1; end
          else if (wdata[7:0] == 8'h20) begin m_errb = 0; m_err = 0; m_ph = 1; m_cnt = LATENCY; end
          else if (wdata[7:0] == 8'h30) begin m_errb = 0; m_err = 0; m_ph = 3; m_ptr = 0; end
          else begin m_errb = 8'h04; m_err = 1; if (!m_nien) m_irq = 1; end
        end
      end else if (m_ph == 1) begin
        m_cnt--;
        if (m_cnt == 0) begin m_ph = 2; m_ptr = 0; end
      end else if (m_ph == 2) begin
        if (rd_en && addr == A_DATA) begin
          m_ptr++;
          if (m_ptr == WORDS) begin m_ph = 0; if (!m_nien) m_irq = 1; end
        end
      end else if (m_ph == 3) begin
        if (wr_en && addr == A_DATA) begin
          m_mem[(m_l0 % SECTORS) * WORDS + m_ptr] = wdata;
          m_ptr++;
          if (m_ptr == WORDS) begin m_ph = 4; m_cnt = LATENCY; end
        end
      end else begin
        m_cnt--;
        if (m_cnt == 0) begin m_ph = 0; if (!m_nien) m_irq = 1; end
      end
      if (wr_en && addr == A_ALT) begin m_nien = wdata[1]; m_srst = wdata[2]; end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [9:0] a);
    logic [7:0] st;
    st = {(m_ph == 1 || m_ph == 4), !(m_ph == 1 || m_ph == 4), 2'b00,
          (m_ph == 2 || m_ph == 3), 2'b00, m_err};
    case (a)
      A_DATA: return (m_ph == 2) ? m_mem[(m_l0 % SECTORS) * WORDS + m_ptr] : 32'h0;
      A_ERR:  return {24'h0, m_errb};
      A_CNT:  return {24'h0, m_cnt_r};
      A_LBA0: return {24'h0, m_l0};
      A_LBA1: return {24'h0, m_l1};
      A_LBA2: return {24'h0, m_l2};
      A_DH:   return {24'h0, 1'b1, m_mode, 1'b1, m_drv, m_hi};
      A_CMD, A_ALT: return {24'h0, st};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  always @(negedge clk) if (running) chk("R6 irq vs model", {31'b0, irq}, {31'b0, m_irq});

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1; wr_en = 0;
    #1 d = rdata;
    if (a == A_DATA) chk("R4 data read vs model", d, exp_rd(a));
    else if (a == A_CMD || a == A_ALT) chk("R2 status vs model", d, exp_rd(a));
    else chk("R1 register vs model", d, exp_rd(a));
    @(posedge clk); #1 rd_en = 0;
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] v);
    @(negedge clk);
    addr = a; wdata = v; wr_en = 1; rd_en = 0;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic poll_busy(output int n);
    logic [31:0] d;
    n = 0;
    for (int k = 0; k < 1000; k++) begin
      rd(A_ALT, d);
      if (d[7]) n++; else break;
    end
  endtask

  function automatic logic [31:0] pat(input int salt, input int i);
    return 32'h5A00_0000 + (salt << 16) + i * 32'h0001_0103;
  endfunction

  task automatic put_sector(input int sec, input int salt);
    logic [31:0] d; int n;
    wr(A_LBA0, sec); wr(A_DH, 32'hE0); wr(A_CMD, 32'h30);
    rd(A_ALT, d); chk("R5 write ready+drq", d, 32'h48);
    for (int i = 0; i < WORDS; i++) wr(A_DATA, pat(salt, i));
    poll_busy(n); chk("R5 commit busy cycles", n, LATENCY);
    rd(A_ALT, d); chk("R5 idle after commit", d, 32'h40);
  endtask

  task automatic get_sector(input int sec, input int salt);
    logic [31:0] d; int n;
    wr(A_LBA0, sec); wr(A_DH, 32'hE0); wr(A_CMD, 32'h20);
    poll_busy(n); chk("R3 read busy cycles", n, LATENCY);
    rd(A_ALT, d); chk("R3 ready+drq", d, 32'h48);
    chk("R6 no irq at data ready", {31'b0, irq}, 32'h0);
    for (int i = 0; i < WORDS; i++) begin
      rd(A_DATA, d); chk("R4 sector word", d, pat(salt, i));
      if (i == WORDS - 2) begin rd(A_ALT, d); chk("R4 drq before last word", d, 32'h48); end
    end
    rd(A_ALT, d); chk("R4 drq clear after last", d, 32'h40);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d; int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1; running = 1;
    rd(A_CMD, d); chk("R2 reset status", d, 32'h40);
    rd(A_ERR, d); chk("R2 reset error", d, 32'h0);
    chk("R2 reset irq", {31'b0, irq}, 32'h0);

    wr(A_CNT, 32'h01); wr(A_LBA1, 32'h34); wr(A_LBA2, 32'h56); wr(A_DH, 32'h0A);
    rd(A_CNT, d); chk("R1 sector count", d, 32'h01);
    rd(A_LBA1, d); chk("R1 lba1", d, 32'h34);
    rd(A_LBA2, d); chk("R1 lba2", d, 32'h56);
    rd(A_DH, d); chk("R1 drive/head fixed bits", d, 32'hAA);
    rd(10'h1F8, d); chk("R1 unmapped", d, 32'h0);

    put_sector(2, 7);
    chk("R6 irq after write", {31'b0, irq}, 32'h1);
    rd(A_ALT, d); chk("R7 alt status keeps irq", {31'b0, irq}, 32'h1);
    rd(A_CMD, d); chk("R7 status read clears irq", {31'b0, irq}, 32'h0);

    get_sector(2, 7);
    chk("R6 irq after read", {31'b0, irq}, 32'h1);
    rd(A_CMD, d);

    wr(A_ALT, 32'h02);
    put_sector(1, 9);
    chk("R6 masked irq", {31'b0, irq}, 32'h0);
    wr(A_ALT, 32'h00);
    get_sector(2, 7);
    rd(A_CMD, d);
    get_sector(1, 9);
    rd(A_CMD, d);

    wr(A_CMD, 32'hEC);
    rd(A_ERR, d); chk("R8 abort code", d, 32'h04);
    rd(A_ALT, d); chk("R8 abort status", d, 32'h41);
    chk("R8 abort irq", {31'b0, irq}, 32'h1);
    rd(A_CMD, d);

    wr(A_LBA0, 32'h02); wr(A_CMD, 32'h20);
    rd(A_ERR, d); chk("R12 error cleared", d, 32'h0);
    rd(A_ALT, d); chk("R12 status error clear", d, 32'h80);
    wr(A_LBA0, 32'h01);
    rd(A_DATA, d); chk("R11 data read outside xfer", d, 32'h0);
    poll_busy(n);
    rd(A_LBA0, d); chk("R11 lba write ignored when active", d, 32'h02);
    for (int i = 0; i < WORDS; i++) rd(A_DATA, d);
    rd(A_CMD, d);
    wr(A_DATA, 32'hDEAD_BEEF);
    get_sector(2, 7);
    rd(A_CMD, d);

    wr(A_DH, 32'hF0); wr(A_CMD, 32'h20);
    rd(A_ERR, d); chk("R9 no-id code", d, 32'h10);
    rd(A_ALT, d); chk("R9 no-id status", d, 32'h41);
    chk("R9 irq", {31'b0, irq}, 32'h1);

    wr(A_ALT, 32'h04);
    rd(A_ALT, d); chk("R10 reset clears error", d, 32'h40);
    rd(A_ERR, d); chk("R10 error byte", d, 32'h0);
    chk("R10 irq low", {31'b0, irq}, 32'h0);
    wr(A_DH, 32'hE0);
    rd(A_DH, d); chk("R10 writes ignored in reset", d, 32'hF0);
    wr(A_ALT, 32'h00);
    wr(A_DH, 32'hE0); wr(A_LBA0, 32'h03); wr(A_CMD, 32'h30);
    wr(A_DATA, 32'h1); wr(A_DATA, 32'h2);
    wr(A_ALT, 32'h04);
    rd(A_ALT, d); chk("R10 abort mid transfer", d, 32'h40);
    wr(A_CMD, 32'h20);
    rd(A_ALT, d); chk("R10 command ignored in reset", d, 32'h40);
    wr(A_ALT, 32'h00);

    repeat (4) @(negedge clk);
    running = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule